// File: doc/BRIEF.md
# Power-up Configuration Loader with CRC Check

After reset this block fetches a sixteen-byte configuration image from a serial EEPROM on a two-wire open-drain bus. It delivers each byte to a register file through a single write port. The first fifteen bytes are folded into an 8-bit CRC, and the result is compared with the sixteenth byte, which holds the stored check value. When the two agree, the block raises a configuration-valid flag. Downstream logic uses this flag to enable the serial position output.

When the check fails, or the EEPROM does not acknowledge, the whole image is read again from byte zero. At most three attempts are made. The active-low error line stays low from reset through the whole load. It goes high only when a load passes. If the third attempt also fails, the line stays low for good and the bus is left idle.

Each byte is fetched as a random read. The block writes the device address with the write bit, then the word address, then issues a repeated start, the device address with the read bit, one data byte closed with a not-acknowledge, and a stop. Every bus bit is split into quarter periods of `QTR_DIV` system clocks. With the default of 313 clocks per quarter at 125 MHz, the bus clock is about 100 kHz and a clean load takes roughly 6.3 ms.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: The byte read from EEPROM word address k is written to register address k (k = 0 to 15). Within an attempt the writes come in ascending address order, starting at 0, and regWrData carries the byte exactly as received.
- R2: Each byte access runs as follows:
  - start, device address `DEV_ADDR` (default 7'h50) followed by a 0 bit, the word address byte,
  - repeated start, the device address followed by a 1 bit,
  - eight data bits, MSB first, closed by the master with a not-acknowledge,
  - stop.
  Exactly one data byte is fetched per access.
- R3: The CRC starts at 8'h00 and is taken over bytes 0 to 14, each byte MSB first. For every bit, the register shifts left by one place and is XORed with 8'h27 when its old MSB differs from the data bit.
- R4: When the CRC equals byte 15, cfgValid goes high and errN is released high.
- R5: When the CRC does not match, the read is repeated from word address 0. At most three attempts are made in total.
- R6: When the third attempt fails, cfgValid stays low, errN stays low, and no further bus transfer is started.
- R7: errN is low from reset and throughout loading. It is never high while cfgValid is low.
- R8: If the EEPROM fails to acknowledge any address byte, the block issues a stop and ends the attempt. That attempt counts as failed under R5 and R6.
- R9: SCL and SDA are only ever pulled low (drive-enable outputs). Both are released while in reset and after loading has ended.
- R10: Once cfgValid is high, it stays high until reset and no further register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; loading starts when it is released |
| sdaIn | input | 1 | Level sensed on the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it to the pull-up |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it to the pull-up |
| regWrEn | output | 1 | One-cycle write strobe to the register file |
| regWrAddr | output | ADDR_W (4) | Register file address being written |
| regWrData | output | 8 | Byte written to the register file |
| errN | output | 1 | Active-low error and loading indication |
| cfgValid | output | 1 | High once the image has passed the CRC check |

## Verification
Several properties are checked on every cycle:
- errN is held low whenever the image is not yet valid, and the valid flag never drops.
- No register write follows acceptance, and the bus is idle once the image is accepted.
- Within an attempt, register writes advance one address at a time.

Other behaviour can only be shown by the bench's scenarios, run against a behavioural EEPROM on the wired-AND lines:
- the CRC polynomial and bit order, and the exact number of attempts;
- the fall-back to a fresh attempt after a refused address;
- the permanent failure after the third bad image, with a quiet bus afterwards;
- the number of data bytes actually fetched, which shows the per-byte random-read sequence.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  // Bus-level operations the datapath sequencer can perform
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } busOp_e;

  // Which byte is shifted out for a write operation
  typedef enum logic [1:0] {
    TX_DEVW = 2'd0,
    TX_WADR = 2'd1,
    TX_DEVR = 2'd2
  } txSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   go;
    busOp_e op;
    txSel_e txSel;
    logic   clrImage;
    logic   nextByte;
    logic   bumpTry;
  } ctlStrobe_t;

  // One byte through the check register, MSB first
  function automatic logic [7:0] crcByte(input logic [7:0] crcIn,
                                         input logic [7:0] data,
                                         input logic [7:0] poly);
    logic [7:0] c;
    c = crcIn;
    for (int k = 7; k >= 0; k--) begin
      if (c[7] ^ data[k]) c = {c[6:0], 1'b0} ^ poly;
      else                c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int         QTR_DIV   = 313,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         NUM_BYTES = 16,
  parameter int         MAX_TRIES = 3,
  parameter logic [7:0] CRC_POLY  = 8'h27,
  localparam int        IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             opDone,
  output logic             ackOk,
  output logic             lastByte,
  output logic             crcMatch,
  output logic             lastTry,
  output logic             regWrEn,
  output logic [IDX_W-1:0] regWrAddr,
  output logic [7:0]       regWrData
);

  localparam int DIV_W = $clog2(QTR_DIV + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [2:0]       phase;
  logic [3:0]       bitCnt;
  busOp_e           opQ;
  logic [8:0]       txShift;
  logic [7:0]       rxShift;
  logic             isBitOp;
  logic             lastPhase;
  logic [7:0]       txByte;
  logic             sclLowQ, sdaLowQ, sclLowC, sdaLowC;
  logic [IDX_W-1:0] byteIdx;
  logic [TRY_W-1:0] tryCnt;
  logic [7:0]       crcQ, chkQ;

  assign tick    = busy && (divCnt == DIV_W'(QTR_DIV - 1));
  assign isBitOp = (opQ == OP_WRITE) || (opQ == OP_READ);

  always_comb begin
    case (opQ)
      OP_START: lastPhase = (phase == 3'd4);
      OP_STOP:  lastPhase = (phase == 3'd3);
      default:  lastPhase = (phase == 3'd3) && (bitCnt == 4'd8);
    endcase
  end

  assign opDone = tick && lastPhase;
  assign ackOk  = !sdaIn;

  always_comb begin
    case (ctl.txSel)
      TX_DEVW: txByte = {DEV_ADDR, 1'b0};
      TX_DEVR: txByte = {DEV_ADDR, 1'b1};
      default: txByte = 8'(byteIdx);
    endcase
  end

  // Line levels per phase; phase 0 keeps SDA so it only moves while SCL is low
  always_comb begin
    sclLowC = sclLowQ;
    sdaLowC = sdaLowQ;
    if (busy) begin
      case (opQ)
        OP_START: begin
          sclLowC = (phase < 3'd2) || (phase == 3'd4);
          sdaLowC = (phase == 3'd0) ? sdaLowQ : (phase >= 3'd3);
        end
        OP_STOP: begin
          sclLowC = (phase < 3'd2);
          sdaLowC = (phase == 3'd0) ? sdaLowQ : (phase < 3'd3);
        end
        default: begin
          sclLowC = (phase < 3'd2);
          sdaLowC = (phase == 3'd0) ? sdaLowQ : !txShift[8];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else begin
      sclLowQ <= sclLowC;
      sdaLowQ <= sdaLowC;
    end
  end

  assign sclDriveLow = sclLowQ;
  assign sdaDriveLow = sdaLowQ;

  // Phase and bit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
      bitCnt  <= '0;
      opQ     <= OP_STOP;
      txShift <= '1;
      rxShift <= '0;
    end else if (ctl.go && !busy) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      phase   <= '0;
      bitCnt  <= '0;
      opQ     <= ctl.op;
      txShift <= (ctl.op == OP_READ) ? 9'h1FF : {txByte, 1'b1};
    end else if (tick) begin
      divCnt <= '0;
      if (isBitOp && phase == 3'd3) rxShift <= {rxShift[6:0], sdaIn};
      if (lastPhase) begin
        busy <= 1'b0;
      end else if (isBitOp && phase == 3'd3) begin
        phase   <= '0;
        bitCnt  <= bitCnt + 4'd1;
        txShift <= {txShift[7:0], 1'b1};
      end else begin
        phase <= phase + 3'd1;
      end
    end else if (busy) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Image bookkeeping: byte index, attempt count, check register
  assign lastByte = (byteIdx == IDX_W'(NUM_BYTES - 1));
  assign lastTry  = (tryCnt == TRY_W'(MAX_TRIES - 1));
  assign crcMatch = (crcQ == chkQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx   <= '0;
      tryCnt    <= '0;
      crcQ      <= '0;
      chkQ      <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (ctl.clrImage) begin
        byteIdx <= '0;
        crcQ    <= '0;
      end else if (ctl.nextByte) begin
        byteIdx <= byteIdx + IDX_W'(1);
      end
      if (ctl.bumpTry) tryCnt <= tryCnt + TRY_W'(1);
      if (opDone && opQ == OP_READ) begin
        regWrEn   <= 1'b1;
        regWrAddr <= byteIdx;
        regWrData <= rxShift;
        if (lastByte) chkQ <= rxShift;
        else          crcQ <= crcByte(crcQ, rxShift, CRC_POLY);
      end
    end
  end

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       opDone,
  input  logic       ackOk,
  input  logic       lastByte,
  input  logic       crcMatch,
  input  logic       lastTry,
  output ctlStrobe_t ctl,
  output logic       errN,
  output logic       cfgValid
);

  typedef enum logic [3:0] {
    S_BEGIN, S_ST1, S_DEVW, S_WADR, S_ST2, S_DEVR, S_READ, S_SP,
    S_NEXT, S_ABORT, S_CHECK, S_RETRY, S_DONE, S_FAIL
  } state_e;

  state_e state, stateNext;
  logic   opState;
  logic   passNow;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    opState   = 1'b0;
    passNow   = 1'b0;
    case (state)
      S_BEGIN: begin
        ctl.clrImage = 1'b1;
        stateNext    = S_ST1;
      end
      S_ST1: begin
        opState = 1'b1;
        ctl.op  = OP_START;
        if (opDone) stateNext = S_DEVW;
      end
      S_DEVW: begin
        opState   = 1'b1;
        ctl.op    = OP_WRITE;
        ctl.txSel = TX_DEVW;
        if (opDone) stateNext = ackOk ? S_WADR : S_ABORT;
      end
      S_WADR: begin
        opState   = 1'b1;
        ctl.op    = OP_WRITE;
        ctl.txSel = TX_WADR;
        if (opDone) stateNext = ackOk ? S_ST2 : S_ABORT;
      end
      S_ST2: begin
        opState = 1'b1;
        ctl.op  = OP_START;
        if (opDone) stateNext = S_DEVR;
      end
      S_DEVR: begin
        opState   = 1'b1;
        ctl.op    = OP_WRITE;
        ctl.txSel = TX_DEVR;
        if (opDone) stateNext = ackOk ? S_READ : S_ABORT;
      end
      S_READ: begin
        opState = 1'b1;
        ctl.op  = OP_READ;
        if (opDone) stateNext = S_SP;
      end
      S_SP: begin
        opState = 1'b1;
        ctl.op  = OP_STOP;
        if (opDone) stateNext = S_NEXT;
      end
      S_ABORT: begin
        opState = 1'b1;
        ctl.op  = OP_STOP;
        if (opDone) stateNext = S_RETRY;
      end
      S_NEXT: begin
        if (lastByte) begin
          stateNext = S_CHECK;
        end else begin
          ctl.nextByte = 1'b1;
          stateNext    = S_ST1;
        end
      end
      S_CHECK: begin
        if (crcMatch) begin
          passNow   = 1'b1;
          stateNext = S_DONE;
        end else begin
          stateNext = S_RETRY;
        end
      end
      S_RETRY: begin
        if (lastTry) begin
          stateNext = S_FAIL;
        end else begin
          ctl.bumpTry  = 1'b1;
          ctl.clrImage = 1'b1;
          stateNext    = S_ST1;
        end
      end
      default: ;
    endcase
    ctl.go = opState && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_BEGIN;
      errN     <= 1'b0;
      cfgValid <= 1'b0;
    end else begin
      state <= stateNext;
      if (passNow) begin
        errN     <= 1'b1;
        cfgValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfgld_pkg::*;
#(
  parameter int         QTR_DIV   = 313,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         NUM_BYTES = 16,
  parameter int         MAX_TRIES = 3,
  parameter logic [7:0] CRC_POLY  = 8'h27,
  localparam int        ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic              errN,
  output logic              cfgValid
);

  ctlStrobe_t ctl;
  logic busy, opDone, ackOk, lastByte, crcMatch, lastTry;

  cfgld_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busy     (busy),
    .opDone   (opDone),
    .ackOk    (ackOk),
    .lastByte (lastByte),
    .crcMatch (crcMatch),
    .lastTry  (lastTry),
    .ctl      (ctl),
    .errN     (errN),
    .cfgValid (cfgValid)
  );

  cfgld_datapath #(
    .QTR_DIV   (QTR_DIV),
    .DEV_ADDR  (DEV_ADDR),
    .NUM_BYTES (NUM_BYTES),
    .MAX_TRIES (MAX_TRIES),
    .CRC_POLY  (CRC_POLY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sdaIn       (sdaIn),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .busy        (busy),
    .opDone      (opDone),
    .ackOk       (ackOk),
    .lastByte    (lastByte),
    .crcMatch    (crcMatch),
    .lastTry     (lastTry),
    .regWrEn     (regWrEn),
    .regWrAddr   (regWrAddr),
    .regWrData   (regWrData)
  );

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclDriveLow,
  input logic              sdaDriveLow,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic              errN,
  input logic              cfgValid
);

  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastAddr <= '0;
    else if (regWrEn) lastAddr <= regWrAddr;
  end

  AST_ERRN_LOW_LOADING: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> !errN); // R7

  AST_ERRN_RISE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errN) |-> cfgValid); // R4

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid); // R10

  AST_NO_WRITE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !regWrEn); // R10

  AST_BUS_IDLE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (!sclDriveLow && !sdaDriveLow)); // R9

  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr != '0) |-> (regWrAddr == ADDR_W'(lastAddr + 1'b1))); // R1

endmodule

bind cfg_eeprom_loader cfgld_checker #(.ADDR_W(ADDR_W)) u_check (
  .clk         (clk),
  .rstN        (rstN),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .regWrEn     (regWrEn),
  .regWrAddr   (regWrAddr),
  .errN        (errN),
  .cfgValid    (cfgValid)
);

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb;

  localparam int         QTR  = 2;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int         WAIT = 22000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       sclDriveLow, sdaDriveLow, regWrEn, errN, cfgValid;
  logic [3:0] regWrAddr;
  logic [7:0] regWrData;
  logic       modelLow = 1'b0;

  wire sclLine = !sclDriveLow;
  wire sdaLine = !(sdaDriveLow || modelLow);

  cfg_eeprom_loader #(.QTR_DIV(QTR), .DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .errN(errN), .cfgValid(cfgValid)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scenario configuration (written only by the stimulus block)
  logic [7:0] mem [16];
  int corruptMask = 0;
  int nackAttempt = 0;
  int nackByte    = 0;

  // Behavioural EEPROM and per-clock comparison
  typedef enum int {M_IDLE, M_DEV, M_WADR, M_TX} mstate_e;
  mstate_e    mst;
  int         slot, attempt, served, starts, expWr;
  logic [7:0] shr, txb;
  logic [3:0] ptr;
  logic       rw, ackIt, prevScl, prevSda, sNow, dNow;
  logic [7:0] lastServed [16];
  logic [7:0] shadow [16];

  function automatic logic [7:0] serve(input logic [3:0] a, input int att);
    if (a == 4'd15 && corruptMask[att-1]) return mem[15] ^ 8'hA5;
    return mem[a];
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      mst = M_IDLE; slot = 0; modelLow = 1'b0; attempt = 0; served = 0;
      starts = 0; expWr = 0; prevScl = 1'b1; prevSda = 1'b1; shr = '0; ptr = '0;
    end else begin
      // R7: error line low whenever the image is not accepted
      if (!cfgValid) check(errN == 1'b0, "R7 errN during load", errN, 0);
      if (regWrEn) begin
        check(regWrAddr == 4'd0 || int'(regWrAddr) == expWr, "R1 write order", regWrAddr, expWr);
        check(regWrData == lastServed[regWrAddr], "R1 write data", regWrData, lastServed[regWrAddr]);
        shadow[regWrAddr] = regWrData;
        expWr = int'(regWrAddr) + 1;
      end
      sNow = sclLine;
      dNow = sdaLine;
      if (sNow && prevScl && prevSda && !dNow) begin
        mst = M_DEV; slot = 0; shr = '0; starts++;
      end else if (sNow && prevScl && !prevSda && dNow) begin
        mst = M_IDLE;
      end else if (!prevScl && sNow) begin
        if (slot < 8) shr = {shr[6:0], dNow};
        slot++;
      end else if (prevScl && !sNow) begin
        if (slot == 8) begin
          case (mst)
            M_DEV: begin
              rw    = shr[0];
              ackIt = (shr[7:1] == DEV) && !(rw && attempt == nackAttempt && int'(ptr) == nackByte);
              modelLow = ackIt;
              if (!ackIt) mst = M_IDLE;
            end
            M_WADR: begin
              ptr = shr[3:0];
              if (shr == 8'd0) attempt++;
              modelLow = 1'b1;
            end
            default: modelLow = 1'b0;
          endcase
        end else if (slot == 9) begin
          slot = 0; shr = '0; modelLow = 1'b0;
          case (mst)
            M_DEV: begin
              if (rw) begin
                mst = M_TX;
                txb = serve(ptr, attempt);
                lastServed[ptr] = txb;
                served++;
                modelLow = !txb[7];
              end else begin
                mst = M_WADR;
              end
            end
            default: mst = M_IDLE;
          endcase
        end else if (mst == M_TX && slot < 8) begin
          modelLow = !txb[7-slot];
        end
      end
      prevScl = sNow;
      prevSda = dNow;
    end
  end

  function automatic logic [7:0] benchCrc();
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 15; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic top = c[7];
        c = c << 1;
        if (top != mem[i][b]) c = c ^ 8'h27;
      end
    end
    return c;
  endfunction

  task automatic runCase(input int pattern, input int cmask, input int nAtt, input int nByte,
                         input bit expOk, input int expAttempts, input int expServed);
    int startsBefore;
    for (int i = 0; i < 15; i++) begin
      case (pattern)
        0:       mem[i] = 8'(i * 37 + 5);
        1:       mem[i] = 8'h00;
        default: mem[i] = 8'(i * i) ^ 8'h5A;
      endcase
    end
    mem[15]     = benchCrc();
    corruptMask = cmask;
    nackAttempt = nAtt;
    nackByte    = nByte;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(errN == 1'b0, "R7 reset errN", errN, 0);
    check(cfgValid == 1'b0, "R10 reset cfgValid", cfgValid, 0);
    check(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0, "R9 reset lines", {sclDriveLow, sdaDriveLow}, 0);
    rstN = 1'b1;
    for (int c = 0; c < WAIT && !cfgValid; c++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(attempt == expAttempts, "R5 attempts", attempt, expAttempts);
    check(served == expServed, "R2 bytes fetched", served, expServed);
    if (expOk) begin
      check(cfgValid == 1'b1, "R3 image accepted", cfgValid, 1);
      check(errN == 1'b1, "R4 errN released", errN, 1);
      for (int i = 0; i < 16; i++)
        check(shadow[i] == mem[i], "R1 register content", shadow[i], mem[i]);
    end else begin
      startsBefore = starts;
      repeat (2000) @(negedge clk);
      check(cfgValid == 1'b0, "R6 not accepted", cfgValid, 0);
      check(errN == 1'b0, "R6 errN held low", errN, 0);
      check(starts == startsBefore, "R6 bus quiet", starts, startsBefore);
    end
    check(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0, "R9 lines released", {sclDriveLow, sdaDriveLow}, 0);
  endtask

  initial begin
    // good image, first attempt
    runCase(0, 0, 0, 0, 1'b1, 1, 16);
    // first attempt corrupt, second good
    runCase(2, 1, 0, 0, 1'b1, 2, 32);
    // two corrupt attempts, third good
    runCase(0, 3, 0, 0, 1'b1, 3, 48);
    // all three corrupt: permanent failure
    runCase(2, 7, 0, 0, 1'b0, 3, 48);
    // R8: missing ack at byte 5 in attempt 1
    runCase(0, 0, 1, 5, 1'b1, 2, 21);
    // all-zero image with zero check byte
    runCase(1, 0, 0, 0, 1'b1, 1, 16);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule